// File: doc/BRIEF.md
# Credit-Gated Packet Transmit Admission

This block sits on the transmit side of a point-to-point link and decides, cycle by cycle, whether the packet now offered may go out. The far end advertises how much receive buffer it has by handing out credits. The block keeps two wrapping counters: a limit that grows with every credit the far end hands back, and a running total of credits spent on packets already sent. A packet is admitted only when its cost fits into the difference between the two.

A packet is offered by holding `req_valid` together with its length in data words. The block turns the length into a credit cost and raises `grant` combinationally in the same cycle when the cost fits. A grant means the packet is sent and its cost is charged at the next clock edge. The starting buffer size is loaded once after reset through the initialisation input, and nothing is granted before that load. Credit returns can arrive in any cycle, including the same cycle as a grant, and both updates take effect together.

Top module: `txcred_gate`

## Requirements
- R1: After reset `grant` is 0 and `credits_avail` is 0 until the first `init_valid`; requests and credit returns made before that load have no effect on `credits_avail`.
- R2: The first cycle with `init_valid` high after reset sets `credits_avail` to `init_credits` from the next cycle on; any later `init_valid` is ignored.
- R3: A packet of `req_words` words costs ceil(`req_words`/4) credits, and a length of 0 costs 1 credit.
- R4: `grant` is high in a cycle exactly when the load has happened, `req_valid` is high, and the packet's cost is at most `credits_avail`.
- R5: A granted packet lowers `credits_avail` by its cost in the next cycle.
- R6: A cycle with `ret_valid` high raises `credits_avail` by `ret_count` in the next cycle.
- R7: A grant and a credit return in the same cycle are both applied: the next `credits_avail` is the old value minus the cost plus `ret_count`.
- R8: The spent-credit total and the limit are 8-bit counters that wrap modulo 256, and admission stays correct however often they wrap.
- R9: A request held high while it does not fit consumes nothing and is granted in the first cycle after a return makes it fit.
- R10: The credits held by a receiver that drains its buffer and returns what it frees never exceed the initial load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| init_valid | input | 1 | Loads the starting credit limit (first one only) |
| init_credits | input | 8 | Starting buffer size in credits |
| req_valid | input | 1 | A packet is offered this cycle |
| req_words | input | 8 | Length of the offered packet in data words |
| ret_valid | input | 1 | The receiver returns credits this cycle |
| ret_count | input | 8 | Number of credits returned |
| grant | output | 1 | The offered packet is sent this cycle |
| credits_avail | output | 8 | Limit minus spent credits, modulo 256 |

## Verification
The bench builds the block with its defaults: 8-bit counters, 8-bit packet lengths and four words per credit. At that size every one of the 256 packet lengths is sent and its charge measured, and every available-credit level from 0 to 70 is probed against every possible cost from 1 to 64, which covers both sides of the fit boundary. Hundreds of combined grant-and-return cycles push both counters past their wrap point several times, and a draining receiver model closes the loop so that buffer occupancy can be compared against the initial load under sustained traffic.

// File: rtl/txcred_pkg.sv
package txcred_pkg;

   // Ceiling division used to size derived widths.
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   // True when the value is a nonzero power of two.
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/txcred_cost.sv
module txcred_cost
   import txcred_pkg::*;
#(
   parameter int LEN_W  = 8,
   parameter int CNT_W  = 8,
   parameter int WPC    = 4
) (
   input  logic [LEN_W-1:0] words,
   output logic [CNT_W-1:0] cost
);

   localparam int SUM_W = LEN_W + 1;
   localparam logic [SUM_W-1:0] ROUND_UP = SUM_W'(WPC - 1);

   logic [SUM_W-1:0] padded;
   logic [SUM_W-1:0] quot;

   assign padded = {1'b0, words} + ROUND_UP;

   generate
      if (is_pow2(WPC)) begin : g_shift
         localparam int SH = $clog2(WPC);
         assign quot = padded >> SH;
      end else begin : g_divide
         assign quot = padded / SUM_W'(WPC);
      end
   endgenerate

   // An empty packet still occupies one buffer slot.
   assign cost = (words == '0) ? CNT_W'(1) : CNT_W'(quot);

endmodule

// File: rtl/txcred_ledger.sv
module txcred_ledger #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_valid,
   input  logic [CNT_W-1:0] init_credits,
   input  logic             take,
   input  logic [CNT_W-1:0] take_cost,
   input  logic             ret_valid,
   input  logic [CNT_W-1:0] ret_count,
   output logic             ready,
   output logic [CNT_W-1:0] avail
);

   logic             ready_q;
   logic [CNT_W-1:0] limit_q;
   logic [CNT_W-1:0] spent_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         limit_q <= '0;
         spent_q <= '0;
      end else if (!ready_q) begin
         if (init_valid) begin
            ready_q <= 1'b1;
            limit_q <= init_credits;
            spent_q <= '0;
         end
      end else begin
         if (take)
            spent_q <= spent_q + take_cost;
         if (ret_valid)
            limit_q <= limit_q + ret_count;
      end
   end

   assign ready = ready_q;
   // Modular difference stays correct across counter wrap.
   assign avail = limit_q - spent_q;

endmodule

// File: rtl/txcred_admit.sv
module txcred_admit #(
   parameter int CNT_W = 8
) (
   input  logic             ready,
   input  logic             req_valid,
   input  logic [CNT_W-1:0] cost,
   input  logic [CNT_W-1:0] avail,
   output logic             grant
);

   logic fits;

   assign fits  = (cost <= avail);
   assign grant = ready & req_valid & fits;

endmodule

// File: rtl/txcred_gate.sv
module txcred_gate
   import txcred_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int LEN_W = 8,
   parameter int WPC   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_valid,
   input  logic [CNT_W-1:0] init_credits,
   input  logic             req_valid,
   input  logic [LEN_W-1:0] req_words,
   input  logic             ret_valid,
   input  logic [CNT_W-1:0] ret_count,
   output logic             grant,
   output logic [CNT_W-1:0] credits_avail
);

   localparam int MAX_COST = ceil_div((1 << LEN_W) - 1, WPC);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("txcred_gate: CNT_W must be at least 2");
      end
      if (WPC < 1) begin : g_bad_wpc
         $error("txcred_gate: WPC must be at least 1");
      end
      if (MAX_COST >= (1 << CNT_W)) begin : g_bad_cost
         $error("txcred_gate: largest packet cost does not fit CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] cost;
   logic             ready;

   txcred_cost #(.LEN_W(LEN_W), .CNT_W(CNT_W), .WPC(WPC)) u_cost (
      .words (req_words),
      .cost  (cost)
   );

   txcred_admit #(.CNT_W(CNT_W)) u_admit (
      .ready     (ready),
      .req_valid (req_valid),
      .cost      (cost),
      .avail     (credits_avail),
      .grant     (grant)
   );

   txcred_ledger #(.CNT_W(CNT_W)) u_ledger (
      .clk          (clk),
      .rst_n        (rst_n),
      .init_valid   (init_valid),
      .init_credits (init_credits),
      .take         (grant),
      .take_cost    (cost),
      .ret_valid    (ret_valid),
      .ret_count    (ret_count),
      .ready        (ready),
      .avail        (credits_avail)
   );

endmodule

// File: rtl/txcred_gate_chk.sv
module txcred_gate_chk #(
   parameter int CNT_W = 8,
   parameter int LEN_W = 8,
   parameter int WPC   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             init_valid,
   input logic [CNT_W-1:0] init_credits,
   input logic             req_valid,
   input logic [LEN_W-1:0] req_words,
   input logic             ret_valid,
   input logic [CNT_W-1:0] ret_count,
   input logic             grant,
   input logic [CNT_W-1:0] credits_avail
);

   logic             seen_q;
   logic [CNT_W-1:0] cost_c;
   logic [CNT_W-1:0] next_c;

   always_ff @(posedge clk) begin
      if (!rst_n)
         seen_q <= 1'b0;
      else if (init_valid)
         seen_q <= 1'b1;
   end

   always_comb begin
      int q;
      q = int'(req_words) / WPC;
      if ((int'(req_words) % WPC) != 0)
         q = q + 1;
      if (q == 0)
         q = 1;
      cost_c = CNT_W'(q);
   end

   always_comb begin
      next_c = credits_avail;
      if (grant)
         next_c = next_c - cost_c;
      if (ret_valid)
         next_c = next_c + ret_count;
   end

   // R1
   a_r1_no_grant_before_load: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> !grant);

   // R2
   a_r2_first_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_q && init_valid) |=> (credits_avail == $past(init_credits)));

   // R4
   a_r4_grant_fits: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (req_valid && (cost_c <= credits_avail)));

   // R4, R9
   a_r9_fit_is_granted: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && req_valid && (cost_c <= credits_avail)) |-> grant);

   // R5, R6, R7, R8
   a_r7_joint_update: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |=> (credits_avail == $past(next_c)));

endmodule

bind txcred_gate txcred_gate_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W), .WPC(WPC)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .init_valid    (init_valid),
   .init_credits  (init_credits),
   .req_valid     (req_valid),
   .req_words     (req_words),
   .ret_valid     (ret_valid),
   .ret_count     (ret_count),
   .grant         (grant),
   .credits_avail (credits_avail)
);

// File: tb/txcred_gate_test.sv
`timescale 1ns/1ps

module txcred_sink_model #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [CNT_W-1:0] push_cost,
   output logic             ret_valid,
   output logic [CNT_W-1:0] ret_count,
   output logic [CNT_W-1:0] occupancy
);
   logic phase_q;
   logic [CNT_W-1:0] occ_q;

   assign ret_valid = phase_q && (occ_q != '0);
   assign ret_count = CNT_W'(1);
   assign occupancy = occ_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         occ_q   <= '0;
      end else begin
         phase_q <= ~phase_q;
         occ_q   <= occ_q + (push ? push_cost : '0) - (ret_valid ? ret_count : '0);
      end
   end
endmodule

module txcred_gate_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       init_valid = 1'b0;
   logic [7:0] init_credits = '0;
   logic       req_valid = 1'b0;
   logic [7:0] req_words = '0;
   logic       tb_ret_valid = 1'b0;
   logic [7:0] tb_ret_count = '0;
   logic       use_sink = 1'b0;
   logic       ret_valid;
   logic [7:0] ret_count;
   logic       grant;
   logic [7:0] credits_avail;
   logic       snk_rv;
   logic [7:0] snk_rc;
   logic [7:0] snk_occ;

   int checks = 0;
   int errors = 0;
   logic [7:0] snk_cost;

   always #5 clk = ~clk;

   assign ret_valid = use_sink ? snk_rv : tb_ret_valid;
   assign ret_count = use_sink ? snk_rc : tb_ret_count;
   assign snk_cost  = (req_words == 0) ? 8'd1 : 8'((int'(req_words) + 3) / 4);

   txcred_gate uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .init_valid    (init_valid),
      .init_credits  (init_credits),
      .req_valid     (req_valid),
      .req_words     (req_words),
      .ret_valid     (ret_valid),
      .ret_count     (ret_count),
      .grant         (grant),
      .credits_avail (credits_avail)
   );

   txcred_sink_model #(.CNT_W(8)) u_sink (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (grant && use_sink),
      .push_cost (snk_cost),
      .ret_valid (snk_rv),
      .ret_count (snk_rc),
      .occupancy (snk_occ)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int cost_of(input int w);
      return (w == 0) ? 1 : (w + 3) / 4;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req_valid = 1'b0;
      init_valid = 1'b0;
      tb_ret_valid = 1'b0;
      use_sink = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int base;
      do_reset();
      // R1: reset state, then requests and returns before the load
      #0.05;
      chk(grant == 1'b0, "R1 grant after reset", grant, 0);
      chk(credits_avail == 8'd0, "R1 avail after reset", credits_avail, 0);
      req_valid = 1'b1; req_words = 8'd4;
      tb_ret_valid = 1'b1; tb_ret_count = 8'd5;
      for (int k = 0; k < 3; k++) begin
         #0.05;
         chk(grant == 1'b0, "R1 no grant before load", grant, 0);
         @(negedge clk);
      end
      chk(credits_avail == 8'd0, "R1 return before load ignored", credits_avail, 0);
      req_valid = 1'b0; tb_ret_valid = 1'b0;

      // R2: first load with zero credits, second load ignored
      init_valid = 1'b1; init_credits = 8'd0;
      @(negedge clk);
      init_valid = 1'b0;
      chk(credits_avail == 8'd0, "R2 load value", credits_avail, 0);
      init_valid = 1'b1; init_credits = 8'd50;
      @(negedge clk);
      init_valid = 1'b0;
      chk(credits_avail == 8'd0, "R2 second load ignored", credits_avail, 0);

      // R4/R6: probe every cost against available levels 0..70
      for (int a = 0; a <= 70; a++) begin
         chk(credits_avail == 8'(a), "R6 return raises avail", credits_avail, a);
         req_valid = 1'b1;
         for (int c = 1; c <= 64; c++) begin
            req_words = 8'(4 * c - 3);
            #0.05;
            chk(grant == (c <= a), "R4 fit decision", grant, (c <= a) ? 1 : 0);
         end
         req_valid = 1'b0;
         tb_ret_valid = 1'b1; tb_ret_count = 8'd1;
         @(negedge clk);
         tb_ret_valid = 1'b0;
      end

      // R3/R5: charge for every length, returned afterwards
      base = 71;
      for (int w = 0; w < 256; w++) begin
         req_valid = 1'b1; req_words = 8'(w);
         #0.05;
         chk(grant == 1'b1, "R4 grant with ample credit", grant, 1);
         @(negedge clk);
         req_valid = 1'b0;
         chk(credits_avail == 8'(base - cost_of(w)), "R3 R5 cost charged",
             credits_avail, base - cost_of(w));
         tb_ret_valid = 1'b1; tb_ret_count = 8'(cost_of(w));
         @(negedge clk);
         tb_ret_valid = 1'b0;
         chk(credits_avail == 8'(base), "R6 credits restored", credits_avail, base);
      end

      // R7/R8: joint grant and return for many wraps
      for (int i = 0; i < 300; i++) begin
         req_valid = 1'b1; req_words = 8'd9;
         tb_ret_valid = 1'b1; tb_ret_count = 8'd3;
         #0.05;
         chk(grant == 1'b1, "R7 grant with return", grant, 1);
         @(negedge clk);
         chk(credits_avail == 8'(base), "R7 R8 joint update across wrap", credits_avail, base);
      end
      req_valid = 1'b1; req_words = 8'd5;
      tb_ret_valid = 1'b1; tb_ret_count = 8'd186;
      @(negedge clk);
      tb_ret_valid = 1'b0; req_valid = 1'b0;
      chk(credits_avail == 8'd255, "R7 joint update to full", credits_avail, 255);

      // R9: drain to 63 then hold a cost-64 request
      req_valid = 1'b1; req_words = 8'd253;
      for (int k = 0; k < 3; k++) @(negedge clk);
      chk(credits_avail == 8'd63, "R8 drained below cost", credits_avail, 63);
      for (int k = 0; k < 3; k++) begin
         #0.05;
         chk(grant == 1'b0, "R9 waits without credit", grant, 0);
         @(negedge clk);
         chk(credits_avail == 8'd63, "R9 waiting consumes nothing", credits_avail, 63);
      end
      tb_ret_valid = 1'b1; tb_ret_count = 8'd1;
      @(negedge clk);
      tb_ret_valid = 1'b0;
      #0.05;
      chk(grant == 1'b1, "R9 granted after return", grant, 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(credits_avail == 8'd0, "R9 charge after wait", credits_avail, 0);

      // R10: closed loop with a draining receiver
      do_reset();
      init_valid = 1'b1; init_credits = 8'd20;
      @(negedge clk);
      init_valid = 1'b0;
      use_sink = 1'b1;
      for (int i = 0; i < 300; i++) begin
         req_valid = 1'b1; req_words = 8'((i * 37 + 5) % 64);
         #0.05;
         while (!grant) begin
            chk(snk_occ <= 8'd20, "R10 occupancy bound", snk_occ, 20);
            @(negedge clk);
            #0.05;
         end
         @(negedge clk);
         chk(snk_occ <= 8'd20, "R10 occupancy bound", snk_occ, 20);
         chk(credits_avail == 8'(20 - int'(snk_occ)), "R10 avail matches free space",
             credits_avail, 20 - int'(snk_occ));
      end
      req_valid = 1'b0;
      repeat (60) @(negedge clk);
      chk(snk_occ == 8'd0, "R10 receiver drained", snk_occ, 0);
      chk(credits_avail == 8'd20, "R10 all credits back", credits_avail, 20);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule